// File: doc/BRIEF.md
# Arbitration-Lost Capture Unit

This unit sits beside the bit-stream sequencer of a CAN controller. While a frame is being sent, it follows the arbitration field one destuffed bit at a time and keeps a running position count. When the controller loses arbitration, the unit records the position of the losing bit in an 8-bit register that the CPU reads. If the arbitration-lost interrupt is enabled, it also raises a pending flag.

The unit takes one capture and then locks. Further losses are ignored until software reads the capture register, and that read re-arms the unit. The interrupt flag is cleared by a read of the interrupt register. The active-low interrupt pin is a combinational function of the flag and the enable. Clearing the enable therefore releases the pin in the same cycle.

Top module: `arb_loss_capture`

## Requirements
- R1: While the unit is armed, an `arb_lost_i` pulse latches the current position into `cap_o[4:0]`, visible after the next clock edge. A bit strobe in the same cycle does not change the captured value, which is the position before that strobe.
- R2: `cap_o[7:5]` always reads 0.
- R3: After a capture, `cap_o` holds its value through any later losses until a `rd_cap_i` pulse re-arms the unit. The next loss after that read is captured.
- R4: After a capture, no further loss can set the interrupt flag until `rd_cap_i` has been pulsed.
- R5: The flag is set in the capture cycle when `irq_en_i` is 1 and is cleared by a `rd_irq_i` pulse. If the flag is set and cleared in the same cycle, the set wins.
- R6: The position map is as follows:
  - 0 to 10 are identifier bits 28 down to 18.
  - 11 is the standard-frame remote bit.
  - 12 is the identifier-extension bit.
  - 13 to 30 are identifier bits 17 down to 0.
  - 31 is the extended-frame remote bit.
- R7: `irq_n_o` is 0 exactly when the flag is set and `irq_en_i` is 1. Dropping `irq_en_i` drives `irq_n_o` high in the same cycle, with no clock edge.
- R8: The position counter does three things:
  - `sof_i` resets it to 0, and `sof_i` has priority over `bit_stb_i`.
  - Each `bit_stb_i` pulse advances it by one.
  - It saturates at 31.
- R9: If a loss and `rd_cap_i` occur in the same cycle, the read sees the old value, the unit re-arms, and that loss is not captured.
- R10: With `irq_en_i` at 0, a loss is still captured but the flag stays clear. Enabling the interrupt later does not assert `irq_n_o`.
- R11: After reset, `cap_o` is 0, the unit is armed, the flag is clear and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Start-of-frame marker, resets the position count |
| bit_stb_i | input | 1 | One pulse per destuffed arbitration bit |
| arb_lost_i | input | 1 | Arbitration-lost pulse |
| rd_cap_i | input | 1 | CPU read strobe of the capture register |
| rd_irq_i | input | 1 | CPU read strobe of the interrupt register |
| irq_en_i | input | 1 | Arbitration-lost interrupt enable |
| cap_o | output | 8 | Capture register value |
| irq_n_o | output | 1 | Interrupt pin, active low |

## Verification
The hardest case to reach from the ports is a loss that arrives while the unit is locked, or in the very cycle that software's read re-arms it. Neither case changes `cap_o`, so the bench must first take a capture and then inject the later loss before any capture read. For the interrupt case, it first clears the flag so that a wrongly raised interrupt would show on `irq_n_o`. For the coincident case, it pulses `arb_lost_i` and `rd_cap_i` together. It then sends one more frame to a known position and checks that the lock was released and that it was the read that released it.

// File: rtl/alc_pkg.sv
package alc_pkg;
  localparam int unsigned POS_W = 5;
  localparam int unsigned CAP_W = 8;
  typedef logic [POS_W-1:0] pos_t;
endpackage

// File: rtl/alc_pos_counter.sv
module alc_pos_counter #(
  parameter int unsigned POS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             bit_stb_i,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] MAX_POS = '1;

  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          pos_q <= '0;
    else if (sof_i)                       pos_q <= '0;
    else if (bit_stb_i && pos_q != MAX_POS) pos_q <= pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/alc_capture_reg.sv
module alc_capture_reg #(
  parameter int unsigned POS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [POS_W-1:0] pos_i,
  input  logic             arb_lost_i,
  input  logic             rd_cap_i,
  output logic             capture_o,
  output logic             armed_o,
  output logic [POS_W-1:0] val_o
);
  logic             armed_q;
  logic [POS_W-1:0] val_q;

  // read re-arms and wins over a coincident loss
  assign capture_o = arb_lost_i & armed_q & ~rd_cap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b1;
      val_q   <= '0;
    end else begin
      if (rd_cap_i)       armed_q <= 1'b1;
      else if (capture_o) armed_q <= 1'b0;
      if (capture_o)      val_q   <= pos_i;
    end
  end

  assign armed_o = armed_q;
  assign val_o   = val_q;
endmodule

// File: rtl/alc_irq_ctrl.sv
module alc_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic irq_en_i,
  input  logic rd_irq_i,
  output logic flag_o,
  output logic irq_n_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flag_q <= 1'b0;
    else if (capture_i && irq_en_i)  flag_q <= 1'b1;
    else if (rd_irq_i)               flag_q <= 1'b0;
  end

  assign flag_o  = flag_q;
  // combinational so disabling releases the pin without delay
  assign irq_n_o = ~(flag_q & irq_en_i);
endmodule

// File: rtl/arb_loss_capture.sv
module arb_loss_capture #(
  parameter int unsigned POS_W = alc_pkg::POS_W,
  parameter int unsigned CAP_W = alc_pkg::CAP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sof_i,
  input  logic             bit_stb_i,
  input  logic             arb_lost_i,
  input  logic             rd_cap_i,
  input  logic             rd_irq_i,
  input  logic             irq_en_i,
  output logic [CAP_W-1:0] cap_o,
  output logic             irq_n_o
);
  localparam int unsigned RSV_W = CAP_W - POS_W;

  logic [POS_W-1:0] pos_w;
  logic [POS_W-1:0] val_w;
  logic             capture_w;
  logic             armed_w;
  logic             flag_w;

  alc_pos_counter #(.POS_W(POS_W)) i_pos (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sof_i     (sof_i),
    .bit_stb_i (bit_stb_i),
    .pos_o     (pos_w)
  );

  alc_capture_reg #(.POS_W(POS_W)) i_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pos_i      (pos_w),
    .arb_lost_i (arb_lost_i),
    .rd_cap_i   (rd_cap_i),
    .capture_o  (capture_w),
    .armed_o    (armed_w),
    .val_o      (val_w)
  );

  alc_irq_ctrl i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (capture_w),
    .irq_en_i  (irq_en_i),
    .rd_irq_i  (rd_irq_i),
    .flag_o    (flag_w),
    .irq_n_o   (irq_n_o)
  );

  generate
    if (RSV_W > 0) begin : g_pad
      assign cap_o = {{RSV_W{1'b0}}, val_w};
    end else begin : g_nopad
      assign cap_o = val_w[CAP_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/alc_checker.sv
module alc_checker #(
  parameter int unsigned POS_W = 5,
  parameter int unsigned CAP_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sof_i,
  input logic             rd_cap_i,
  input logic             rd_irq_i,
  input logic             irq_en_i,
  input logic [CAP_W-1:0] cap_o,
  input logic             irq_n_o,
  input logic [POS_W-1:0] pos_w,
  input logic             armed_w,
  input logic             capture_w,
  input logic             flag_w
);
  p_capture_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_w |=> cap_o[POS_W-1:0] == $past(pos_w));

  p_reserved_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_o >> POS_W) == '0);

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_w && !rd_cap_i) |=> $stable(cap_o));

  p_no_irq_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_w |=> !$rose(flag_w));

  p_flag_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_irq_i && !capture_w) |=> !flag_w);

  p_pin_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> irq_n_o);

  p_sof_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_i |=> pos_w == '0);

  p_saturate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&pos_w && !sof_i) |=> &pos_w);

  p_read_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cap_i |=> (armed_w && $stable(cap_o)));

  p_no_flag_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !flag_w) |=> !flag_w);
endmodule

bind arb_loss_capture alc_checker #(.POS_W(POS_W), .CAP_W(CAP_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sof_i     (sof_i),
  .rd_cap_i  (rd_cap_i),
  .rd_irq_i  (rd_irq_i),
  .irq_en_i  (irq_en_i),
  .cap_o     (cap_o),
  .irq_n_o   (irq_n_o),
  .pos_w     (pos_w),
  .armed_w   (armed_w),
  .capture_w (capture_w),
  .flag_w    (flag_w)
);

// File: tb/test_arb_loss_capture.sv
module test_arb_loss_capture;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sof = 1'b0, bit_stb = 1'b0, arb_lost = 1'b0;
  logic       rd_cap = 1'b0, rd_irq = 1'b0, irq_en = 1'b0;
  logic [7:0] cap;
  logic       irq_n;
  int         n_chk = 0;
  int         n_err = 0;

  localparam int P_SRTR = 11, P_IDE = 12, P_ID0 = 30, P_RTR_EXT = 31;

  always #10 clk = ~clk;

  arb_loss_capture i_arb_loss_capture (
    .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .bit_stb_i(bit_stb),
    .arb_lost_i(arb_lost), .rd_cap_i(rd_cap), .rd_irq_i(rd_irq),
    .irq_en_i(irq_en), .cap_o(cap), .irq_n_o(irq_n)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_to(int k);
    sof = 1'b1; tick(); sof = 1'b0;
    for (int i = 0; i < k; i++) begin
      bit_stb = 1'b1; tick(); bit_stb = 1'b0;
    end
  endtask

  task automatic lose_at(int k);
    run_to(k);
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
  endtask

  task automatic rearm();
    rd_cap = 1'b1; rd_irq = 1'b1; tick(); rd_cap = 1'b0; rd_irq = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 cap after reset", cap, 0);
    chk("R11 irq_n after reset", irq_n, 1);
    chk("R2 reserved after reset", cap[7:5], 0);
  endtask

  task automatic t_basic();
    irq_en = 1'b1;
    lose_at(5);
    chk("R1 captured position", cap, 5);
    chk("R5 flag raises pin", irq_n, 0);
    rd_irq = 1'b1; tick(); rd_irq = 1'b0;
    chk("R5 interrupt read clears", irq_n, 1);
  endtask

  task automatic t_lock();
    lose_at(9);
    chk("R3 locked value held", cap, 5);
    chk("R4 no interrupt while locked", irq_n, 1);
    rd_cap = 1'b1; tick(); rd_cap = 1'b0;
    lose_at(9);
    chk("R3 re-armed capture", cap, 9);
    chk("R4 interrupt after re-arm", irq_n, 0);
    rearm();
  endtask

  task automatic t_map();
    lose_at(P_IDE);  chk("R6 identifier-extension bit", cap, 12);  rearm();
    lose_at(P_SRTR); chk("R6 standard remote bit", cap, 11);       rearm();
    lose_at(P_ID0);  chk("R6 identifier bit 0", cap, 30);          rearm();
    lose_at(P_RTR_EXT); chk("R6 extended remote bit", cap, 31);
    chk("R2 reserved at 31", cap[7:5], 0);
    rearm();
  endtask

  task automatic t_counter();
    lose_at(40); chk("R8 saturate", cap, 31); rearm();
    run_to(10);
    sof = 1'b1; bit_stb = 1'b1; tick(); sof = 1'b0; bit_stb = 1'b0;
    bit_stb = 1'b1; tick(); tick(); bit_stb = 1'b0;
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
    chk("R8 sof restarts count", cap, 2);
    rearm();
    run_to(7);
    arb_lost = 1'b1; bit_stb = 1'b1; tick(); arb_lost = 1'b0; bit_stb = 1'b0;
    chk("R1 strobe same cycle", cap, 7);
    rearm();
  endtask

  task automatic t_same_cycle();
    lose_at(3); rearm();
    run_to(4);
    arb_lost = 1'b1; rd_cap = 1'b1; #1;
    chk("R9 read sees old value", cap, 3);
    tick(); arb_lost = 1'b0; rd_cap = 1'b0;
    chk("R9 coincident loss dropped", cap, 3);
    chk("R9 no interrupt", irq_n, 1);
    lose_at(6);
    chk("R9 re-armed by read", cap, 6);
    rearm();
  endtask

  task automatic t_disabled();
    irq_en = 1'b0;
    lose_at(7);
    chk("R10 capture while disabled", cap, 7);
    chk("R10 pin high", irq_n, 1);
    irq_en = 1'b1; #1;
    chk("R10 no late interrupt", irq_n, 1);
    rearm();
  endtask

  task automatic t_pin_release();
    irq_en = 1'b1;
    lose_at(8);
    chk("R7 pin low", irq_n, 0);
    irq_en = 1'b0; #1;
    chk("R7 pin high without edge", irq_n, 1);
    irq_en = 1'b1; #1;
    chk("R7 pin low again", irq_n, 0);
    rearm();
  endtask

  task automatic t_set_wins();
    irq_en = 1'b1;
    run_to(2);
    arb_lost = 1'b1; rd_irq = 1'b1; tick(); arb_lost = 1'b0; rd_irq = 1'b0;
    chk("R5 set wins over clear", irq_n, 0);
    rearm();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rst_n = 1'b1; tick();
    t_reset();
    t_basic();
    t_lock();
    t_map();
    t_counter();
    t_same_cycle();
    t_disabled();
    t_pin_release();
    t_set_wins();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule